// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting timer channel. It advances only on cycles where a count-enable tick is present. It has a gate input and one output level, and offers six counting modes: terminal-count flag, retriggerable one-shot, rate generator, square wave, and a strobe started either by software or by the gate. A register front end (outside this block) writes a configuration (mode and decimal/binary select) and a 16-bit initial count into the channel.

The live count and the output level are brought out as plain signals, so the front end can latch them when software reads them. The channel reloads the count, wraps it at the end of the range, restarts on gate edges and shapes the output waveform for the selected mode. Bus decoding, byte sequencing, read-back latching and interrupt delivery stay in the front end.

Top module: `interval_counter`

## Requirements
- R1: While reset is held, and at the first edge after it, `countOut` is 0 and `outLevel` is low. The channel comes out of reset in mode 0 (binary) with an initial count of 0 waiting to load, so gate high plus one tick loads the count.
- R2: `countOut` changes only at a clock edge where `tick` is high. With no tick it holds, even if a count is written.
- R3: An initial count of 0 means 65536 in binary and 10000 in decimal. In mode 0 with count 0, `outLevel` stays low 65535 ticks after the load tick and goes high on the 65536th. In decimal the same happens on the 10000th tick.
- R4: In modes 0, 1, 4 and 5 the counter keeps running past zero. It wraps to 0xFFFF in binary or to 0x9999 in decimal. In decimal each hex nibble is one digit, so 0x0100 minus one tick gives 0x0099.
- R5: Mode 0 (`cfgMode`=0): the load tick sets `outLevel` low. The output rises on the tick where the count goes from 1 to 0 and stays high. In modes 0 and 4 a low gate freezes the count.
- R6: Mode 1: after the config write `outLevel` is high and the count stays put until a rising gate edge. The next tick loads the count and drives `outLevel` low. The output goes high when the count reaches 0. Counting ignores the gate level after that, and a new rising edge reloads the count.
- R7: Mode 2: the count reloads on the tick where it is 1. `outLevel` is low for exactly that one tick and high otherwise. A low gate freezes the count and holds the output high. A rising gate edge reloads on the next tick.
- R8: Mode 3: the count steps by 2 from the initial count rounded down to even. The output is high for (N+1)/2 ticks and low for N/2 ticks, rounded down, for any N of 2 or more. A low gate forces the output high and freezes the count.
- R9: Mode 4: the output drops low for one tick when the count goes from 1 to 0. That happens once per load, and wrapping does not repeat it.
- R10: Mode 5 behaves like mode 4 but starts only on a rising gate edge. Once started it counts whatever the gate level.
- R11: Mode field values 6 and 7 act as modes 2 and 3.
- R12: A written count takes effect on the next tick in modes 0, 2, 3 and 4, and at the next gate trigger in modes 1 and 5.
- R13: A configuration write stops counting until a new load. It sets `outLevel` low for mode 0 and high for every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one clock wide per count step |
| gate | input | 1 | Gate level; rising edges act as triggers |
| cfgWr | input | 1 | Configuration write strobe |
| cfgMode | input | 3 | Mode field, 0 to 7 |
| cfgBcd | input | 1 | 1 selects decimal (one digit per nibble) counting |
| cntWr | input | 1 | Initial-count write strobe |
| cntValue | input | 16 | Initial count, 0 meaning the full range |
| countOut | output | 16 | Live counter value |
| outLevel | output | 1 | Channel output |

## Verification
Every result is held in a register. The count and output that follow a tick appear one clock after the edge that sampled the tick, with no further pipeline. Configuration writes change the output by the same edge. A count write alters nothing visible until a later tick. A gate edge seen on a non-tick edge is held until the next tick. The bench drives every input on the falling clock edge and reads the outputs on the falling edge right after the ticking rising edge. So each expected value is compared exactly one edge after its cause.

// File: rtl/interval_counter_pkg.sv
`timescale 1ns/1ps
package interval_counter_pkg;
  localparam int MODE_BITS = 3;

  typedef enum logic [MODE_BITS-1:0] {
    MODE_TERM     = 3'd0,
    MODE_ONESHOT  = 3'd1,
    MODE_RATE     = 3'd2,
    MODE_SQUARE   = 3'd3,
    MODE_SWSTROBE = 3'd4,
    MODE_HWSTROBE = 3'd5
  } chMode_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic loadInit;    // capture a new initial count
    logic reload;      // copy initial count into the counter
    logic reloadEven;  // reload with bit 0 cleared
    logic decrement;   // step the counter down
    logic stepTwo;     // step size two instead of one
  } dpCmd_t;
endpackage

// File: rtl/interval_counter_dp.sv
`timescale 1ns/1ps
module interval_counter_dp
  import interval_counter_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic             bcd,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] count,
  output logic             initOdd,
  output logic             isOne,
  output logic             isTwo
);
  localparam int DIGITS = WIDTH / 4;

  logic [WIDTH-1:0] initQ;
  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] evenInit;
  logic [WIDTH-1:0] stepped;

  // Subtract 1 or 2, wrapping binary to all ones and decimal to all nines.
  function automatic logic [WIDTH-1:0] stepDown(input logic [WIDTH-1:0] v,
                                                input logic [1:0] s,
                                                input logic useBcd);
    logic [WIDTH-1:0] r;
    logic [4:0] d;
    logic [1:0] borrow;
    if (!useBcd) return v - WIDTH'(s);
    r = '0;
    borrow = s;
    for (int i = 0; i < DIGITS; i++) begin
      d = {1'b0, v[i*4 +: 4]} - {3'b000, borrow};
      if (d[4]) begin
        r[i*4 +: 4] = 4'(d + 5'd10);
        borrow = 2'd1;
      end else begin
        r[i*4 +: 4] = d[3:0];
        borrow = 2'd0;
      end
    end
    return r;
  endfunction

  assign evenInit = {initQ[WIDTH-1:1], 1'b0};
  assign stepped  = stepDown(countQ, cmd.stepTwo ? 2'd2 : 2'd1, bcd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initQ  <= '0;
      countQ <= '0;
    end else begin
      if (cmd.loadInit) initQ <= loadValue;
      if (cmd.reload) countQ <= cmd.reloadEven ? evenInit : initQ;
      else if (cmd.decrement) countQ <= stepped;
    end
  end

  assign count   = countQ;
  assign initOdd = initQ[0];
  assign isOne   = (countQ == WIDTH'(1));
  assign isTwo   = (countQ == WIDTH'(2));
endmodule

// File: rtl/interval_counter_ctrl.sv
`timescale 1ns/1ps
module interval_counter_ctrl
  import interval_counter_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 gate,
  input  logic                 cfgWr,
  input  logic [MODE_BITS-1:0] cfgMode,
  input  logic                 cfgBcd,
  input  logic                 cntWr,
  input  logic                 initOdd,
  input  logic                 isOne,
  input  logic                 isTwo,
  output dpCmd_t               cmd,
  output logic                 bcd,
  output logic                 outLevel
);
  chMode_e modeQ, modeD, cfgDecoded;
  logic bcdQ, bcdD, outQ, outD, activeQ, activeD, armedQ, armedD;
  logic loadPendQ, loadPendD, trigPendQ, trigPendD, stretchQ, stretchD;
  logic gatePrevQ, gateRise, trigSeen, start;

  // Field values 6 and 7 fold onto the periodic modes.
  function automatic chMode_e decodeMode(input logic [MODE_BITS-1:0] m);
    if (m[2] && m[1]) return chMode_e'({1'b0, m[1:0]});
    return chMode_e'(m);
  endfunction

  assign cfgDecoded = decodeMode(cfgMode);
  assign gateRise   = gate && !gatePrevQ;
  assign trigSeen   = trigPendQ || gateRise;
  assign start = (modeQ == MODE_ONESHOT || modeQ == MODE_HWSTROBE) ? trigSeen :
                 (modeQ == MODE_RATE || modeQ == MODE_SQUARE) ? (loadPendQ || trigSeen) :
                 loadPendQ;

  always_comb begin
    cmd = '0;
    cmd.loadInit = cntWr;
    modeD = modeQ;
    bcdD = bcdQ;
    outD = outQ;
    activeD = activeQ;
    armedD = armedQ;
    loadPendD = loadPendQ || cntWr;
    trigPendD = trigSeen;
    stretchD = stretchQ;
    if (cfgWr) begin
      modeD = cfgDecoded;
      bcdD = cfgBcd;
      outD = (cfgDecoded != MODE_TERM);
      activeD = 1'b0;
      armedD = 1'b0;
      loadPendD = cntWr;
      trigPendD = 1'b0;
      stretchD = 1'b0;
    end else if (tick) begin
      trigPendD = 1'b0;
      if (start) begin
        cmd.reload = 1'b1;
        cmd.reloadEven = (modeQ == MODE_SQUARE);
        activeD = 1'b1;
        armedD = 1'b1;
        loadPendD = cntWr;
        outD = !(modeQ == MODE_TERM || modeQ == MODE_ONESHOT);
        stretchD = initOdd;
      end else if (activeQ) begin
        case (modeQ)
          MODE_TERM, MODE_ONESHOT: begin
            if (gate || modeQ == MODE_ONESHOT) begin
              cmd.decrement = 1'b1;
              if (isOne && armedQ) begin
                outD = 1'b1;
                armedD = 1'b0;
              end
            end
          end
          MODE_RATE: begin
            if (gate) begin
              if (isOne) begin
                cmd.reload = 1'b1;
                outD = 1'b0;
              end else begin
                cmd.decrement = 1'b1;
                outD = 1'b1;
              end
            end else outD = 1'b1;
          end
          MODE_SQUARE: begin
            if (gate) begin
              if (stretchQ) stretchD = 1'b0;
              else if (isTwo) begin
                cmd.reload = 1'b1;
                cmd.reloadEven = 1'b1;
                outD = !outQ;
                stretchD = !outQ && initOdd;
              end else begin
                cmd.decrement = 1'b1;
                cmd.stepTwo = 1'b1;
              end
            end else outD = 1'b1;
          end
          default: begin
            if (gate || modeQ == MODE_HWSTROBE) begin
              cmd.decrement = 1'b1;
              outD = !(isOne && armedQ);
              if (isOne) armedD = 1'b0;
            end else outD = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_TERM;
      bcdQ <= 1'b0;
      outQ <= 1'b0;
      activeQ <= 1'b0;
      armedQ <= 1'b0;
      loadPendQ <= 1'b1;
      trigPendQ <= 1'b0;
      stretchQ <= 1'b0;
      gatePrevQ <= 1'b0;
    end else begin
      modeQ <= modeD;
      bcdQ <= bcdD;
      outQ <= outD;
      activeQ <= activeD;
      armedQ <= armedD;
      loadPendQ <= loadPendD;
      trigPendQ <= trigPendD;
      stretchQ <= stretchD;
      gatePrevQ <= gate;
    end
  end

  assign bcd = bcdQ;
  assign outLevel = outQ;
endmodule

// File: rtl/interval_counter.sv
`timescale 1ns/1ps
module interval_counter
  import interval_counter_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 gate,
  input  logic                 cfgWr,
  input  logic [MODE_BITS-1:0] cfgMode,
  input  logic                 cfgBcd,
  input  logic                 cntWr,
  input  logic [WIDTH-1:0]     cntValue,
  output logic [WIDTH-1:0]     countOut,
  output logic                 outLevel
);
  dpCmd_t dpCmd;
  logic bcdSel, initOdd, isOne, isTwo;

  interval_counter_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .gate(gate),
    .cfgWr(cfgWr), .cfgMode(cfgMode), .cfgBcd(cfgBcd), .cntWr(cntWr),
    .initOdd(initOdd), .isOne(isOne), .isTwo(isTwo),
    .cmd(dpCmd), .bcd(bcdSel), .outLevel(outLevel)
  );

  interval_counter_dp #(.WIDTH(WIDTH)) i_dp (
    .clk(clk), .rstN(rstN), .cmd(dpCmd), .bcd(bcdSel),
    .loadValue(cntValue), .count(countOut),
    .initOdd(initOdd), .isOne(isOne), .isTwo(isTwo)
  );
endmodule

// File: rtl/interval_counter_chk.sv
`timescale 1ns/1ps
module interval_counter_chk
  import interval_counter_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             cfgWr,
  input logic [WIDTH-1:0] countOut,
  input logic             outLevel,
  input dpCmd_t           dpCmd
);
  // R1: reset values are visible at the first edge after release
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (countOut == '0 && !outLevel));

  // R2: the counter only moves on tick edges
  a_r2_count_holds: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(countOut));

  // R13: output only moves on tick edges or configuration writes
  a_r13_out_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !cfgWr) |=> $stable(outLevel));

  // R12: a reload only ever happens on a tick edge
  a_r12_reload_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    dpCmd.reload |-> tick);
endmodule

bind interval_counter interval_counter_chk #(.WIDTH(WIDTH)) i_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .cfgWr(cfgWr),
  .countOut(countOut), .outLevel(outLevel), .dpCmd(dpCmd)
);

// File: tb/test_interval_counter.sv
`timescale 1ns/1ps
module test_interval_counter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, gate = 1'b1, cfgWr = 1'b0, cfgBcd = 1'b0, cntWr = 1'b0;
  logic [2:0] cfgMode = 3'd0;
  logic [15:0] cntValue = 16'd0;
  logic [15:0] countOut;
  logic outLevel;
  int nChecks = 0, nFails = 0;
  logic [15:0] saved;

  always #2.5 clk = ~clk;

  interval_counter i_interval_counter (
    .clk(clk), .rstN(rstN), .tick(tick), .gate(gate), .cfgWr(cfgWr),
    .cfgMode(cfgMode), .cfgBcd(cfgBcd), .cntWr(cntWr), .cntValue(cntValue),
    .countOut(countOut), .outLevel(outLevel)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect2(input string tag, input logic [15:0] c, input logic o);
    check({tag, " count"}, 32'(countOut), 32'(c));
    check({tag, " out"}, 32'(outLevel), 32'(o));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic configure(input logic [2:0] m, input logic b);
    cfgWr = 1'b1; cfgMode = m; cfgBcd = b;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic loadCount(input logic [15:0] v);
    cntWr = 1'b1; cntValue = v;
    @(negedge clk);
    cntWr = 1'b0;
  endtask

  task automatic riseGate();
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  task automatic testReset();
    gate = 1'b1;
    repeat (3) @(negedge clk);
    expect2("R1 in reset", 16'h0000, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    expect2("R1 after release", 16'h0000, 1'b0);
    loadCount(16'h1234);
    repeat (2) @(negedge clk);
    expect2("R2 no tick holds", 16'h0000, 1'b0);
    configure(3'd0, 1'b0);
    loadCount(16'h0000);
    ticks(1);
    expect2("R3 load zero", 16'h0000, 1'b0);
    ticks(65535);
    expect2("R3 one before full range", 16'h0001, 1'b0);
    ticks(1);
    expect2("R3 full binary range", 16'h0000, 1'b1);
    ticks(1);
    expect2("R4 binary wrap", 16'hFFFF, 1'b1);
  endtask

  task automatic testMode0();
    gate = 1'b1;
    configure(3'd0, 1'b0);
    check("R13 mode0 out low", 32'(outLevel), 32'd0);
    loadCount(16'd5);
    ticks(1);
    expect2("R12 mode0 load on tick", 16'd5, 1'b0);
    gate = 1'b0;
    ticks(3);
    expect2("R5 gate low freezes", 16'd5, 1'b0);
    gate = 1'b1;
    ticks(4);
    expect2("R5 before terminal", 16'd1, 1'b0);
    ticks(1);
    expect2("R5 terminal", 16'd0, 1'b1);
    ticks(1);
    expect2("R5 stays high", 16'hFFFF, 1'b1);
  endtask

  task automatic testBcd();
    gate = 1'b1;
    configure(3'd0, 1'b1);
    loadCount(16'h0000);
    ticks(1);
    ticks(9999);
    expect2("R3 decimal one before", 16'h0001, 1'b0);
    ticks(1);
    expect2("R3 decimal full range", 16'h0000, 1'b1);
    ticks(1);
    expect2("R4 decimal wrap", 16'h9999, 1'b1);
    loadCount(16'h0100);
    ticks(1);
    check("R12 decimal reload", 32'(countOut), 32'h0100);
    ticks(1);
    check("R4 decimal borrow", 32'(countOut), 32'h0099);
  endtask

  task automatic testMode1();
    gate = 1'b1;
    configure(3'd1, 1'b0);
    check("R13 mode1 out high", 32'(outLevel), 32'd1);
    saved = countOut;
    loadCount(16'd3);
    ticks(2);
    expect2("R6 waits for trigger", saved, 1'b1);
    riseGate();
    ticks(1);
    expect2("R6 triggered", 16'd3, 1'b0);
    ticks(2);
    expect2("R6 counting", 16'd1, 1'b0);
    ticks(1);
    expect2("R6 terminal", 16'd0, 1'b1);
    ticks(1);
    expect2("R4 mode1 wrap", 16'hFFFF, 1'b1);
    riseGate();
    ticks(1);
    expect2("R6 retrigger", 16'd3, 1'b0);
    gate = 1'b0;
    ticks(1);
    expect2("R6 ignores gate level", 16'd2, 1'b0);
  endtask

  task automatic testMode2();
    gate = 1'b1;
    configure(3'd2, 1'b0);
    loadCount(16'd4);
    ticks(1);
    expect2("R7 load", 16'd4, 1'b1);
    ticks(3);
    expect2("R7 before strobe", 16'd1, 1'b1);
    ticks(1);
    expect2("R7 strobe and reload", 16'd4, 1'b0);
    ticks(1);
    expect2("R7 strobe one tick", 16'd3, 1'b1);
    gate = 1'b0;
    ticks(2);
    expect2("R7 gate low", 16'd3, 1'b1);
    riseGate();
    ticks(1);
    expect2("R7 gate retrigger", 16'd4, 1'b1);
    loadCount(16'd6);
    ticks(1);
    check("R12 mode2 new count next tick", 32'(countOut), 32'd6);
    configure(3'd6, 1'b0);
    loadCount(16'd3);
    ticks(1);
    ticks(2);
    expect2("R11 mode6 before strobe", 16'd1, 1'b1);
    ticks(1);
    expect2("R11 mode6 acts as mode2", 16'd3, 1'b0);
  endtask

  task automatic testMode3();
    gate = 1'b1;
    configure(3'd3, 1'b0);
    loadCount(16'd5);
    ticks(1);
    expect2("R8 odd load", 16'd4, 1'b1);
    ticks(1);
    expect2("R8 odd extra high tick", 16'd4, 1'b1);
    ticks(1);
    expect2("R8 odd step two", 16'd2, 1'b1);
    ticks(1);
    expect2("R8 odd low phase", 16'd4, 1'b0);
    ticks(1);
    expect2("R8 odd low phase 2", 16'd2, 1'b0);
    ticks(1);
    expect2("R8 odd back high", 16'd4, 1'b1);
    ticks(3);
    expect2("R8 second low", 16'd4, 1'b0);
    gate = 1'b0;
    ticks(1);
    expect2("R8 gate low forces high", 16'd4, 1'b1);
    gate = 1'b1;
    configure(3'd7, 1'b0);
    loadCount(16'd4);
    ticks(1);
    expect2("R11 mode7 load", 16'd4, 1'b1);
    ticks(1);
    expect2("R11 mode7 step", 16'd2, 1'b1);
    ticks(1);
    expect2("R11 mode7 low", 16'd4, 1'b0);
    ticks(2);
    expect2("R11 mode7 high again", 16'd4, 1'b1);
  endtask

  task automatic testMode4();
    gate = 1'b1;
    configure(3'd4, 1'b1);
    loadCount(16'h0002);
    ticks(1);
    expect2("R9 load", 16'h0002, 1'b1);
    ticks(1);
    expect2("R9 before strobe", 16'h0001, 1'b1);
    ticks(1);
    expect2("R9 strobe", 16'h0000, 1'b0);
    ticks(1);
    expect2("R9 strobe ends, R4 wrap", 16'h9999, 1'b1);
    ticks(9999);
    expect2("R9 no second strobe", 16'h0000, 1'b1);
    gate = 1'b0;
    ticks(2);
    expect2("R5 mode4 gate freezes", 16'h0000, 1'b1);
    gate = 1'b1;
  endtask

  task automatic testMode5();
    gate = 1'b1;
    configure(3'd5, 1'b0);
    saved = countOut;
    loadCount(16'd2);
    ticks(2);
    expect2("R10 waits for trigger", saved, 1'b1);
    riseGate();
    ticks(1);
    expect2("R10 triggered", 16'd2, 1'b1);
    gate = 1'b0;
    ticks(1);
    expect2("R10 counts with gate low", 16'd1, 1'b1);
    ticks(1);
    expect2("R10 strobe", 16'd0, 1'b0);
    ticks(1);
    expect2("R10 after strobe", 16'hFFFF, 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    @(negedge clk);
    testReset();
    testMode0();
    testBcd();
    testMode1();
    testMode2();
    testMode3();
    testMode4();
    testMode5();
    finishRun();
  end
endmodule